// File: doc/BRIEF.md
# Clocked Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link: a transfer clock, a serial output and a serial input. A processor reaches it through two byte-wide registers on a one-bit address: address 0 is the data/shift register, address 1 is the control register. Writing a byte to address 0 arms a transfer. The port then drives bits out on each falling edge of the transfer clock and captures the input line on each rising edge, so the register holds the received byte when the transfer ends.

The transfer clock comes either from an internal divider of the system clock or from an external pin. In internal mode the port drives the clock, stops it high after eight bits and floats its serial output. In external mode the port counts eight rising edges, then raises its request flag, but it keeps shifting on any further edges the far side supplies. A sticky request flag reports completion in both modes.

Top module: `sio_port`

## Requirements
- R1: A write to address 0 loads the byte into the shift register, arms the transfer and forces the internal transfer clock high. A read of address 0 returns the shift register, so it returns the written byte right after the write.
- R2: Control bit 5 selects the bit order: 0 sends the least significant bit first, 1 sends the most significant bit first. Each falling transfer-clock edge places the next bit on `sout`, and the bit stays there through the following rising edge.
- R3: Each rising transfer-clock edge samples `sin` and shifts it in. After eight rising edges, address 0 reads the received byte. The first received bit lands in bit 0 in LSB-first order and in bit 7 in MSB-first order.
- R4: With control bit 0 = 0 (internal clock), `sclk_out` toggles every `HALF` system cycles. Its first falling edge comes `HALF` cycles after the write edge. The request flag sets `16*HALF` cycles after the write edge, and the clock then rests high.
- R5: In internal mode, `sout_oe` is high only while a transfer runs and `sclk_oe` is high. In external mode, `sout_oe` stays high and `sclk_oe` is low.
- R6: With control bit 0 = 1 (external clock), `sclk_in` passes through a two-flop synchroniser. The request flag sets on the eighth rising edge after the write. Any further edges keep moving data through `sout` and the shift register.
- R7: The request flag sets when a transfer completes and reads as control bit 7 and on `irq`. Only a control write with bit 7 = 0 clears it. A control write with bit 7 = 1, or a data write, leaves it set.
- R8: A change of control bit 0 made during a transfer has no effect on that transfer. It takes effect once the port is idle.
- R9: After reset: `sout_oe` = 0, `sclk_out` = 1, `sclk_oe` = 1, `irq` = 0, and both registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 1 | Register select: 0 data, 1 control |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internally generated transfer clock |
| sclk_oe | output | 1 | Drive enable for the transfer clock pin |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output |
| sout_oe | output | 1 | Drive enable for the serial output pin |
| irq | output | 1 | Sticky transfer-complete request |

## Verification
In internal mode the results fall on exact cycles after the write edge. The first falling clock edge comes after `HALF` cycles and the request after `16*HALF` cycles. The bench counts system-clock edges from the write and samples one cycle early and on the due cycle. In external mode each outcome trails its pin edge by three cycles: two synchroniser flops and the edge register. The bench therefore holds every clock level for six cycles before it samples. Serial output bits are not timed by the bench directly. A monitor compares each bit with the head of the expected queue on every rising transfer-clock edge it sees at the pins. The same monitor feeds `sin` on each falling edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned CTL_EXT  = 0;
  localparam int unsigned CTL_MSB  = 5;
  localparam int unsigned CTL_FLAG = 7;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sio_int_clk.sv
module sio_int_clk #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int unsigned TW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [TW-1:0] TOP = TW'(HALF - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick = run && (tmr_q == TOP);
  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;
  assign sclk = sclk_q;

  always_comb begin
    tmr_d  = tmr_q;
    sclk_d = sclk_q;
    if (load) begin
      tmr_d  = '0;
      sclk_d = 1'b1;
    end else if (tick) begin
      tmr_d  = '0;
      sclk_d = !sclk_q;
    end else if (run) begin
      tmr_d  = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      sclk_q <= 1'b1;
    end else if (load || run) begin
      tmr_q  <= tmr_d;
      sclk_q <= sclk_d;
    end
  end

  // R4: an idle internal clock rests high
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sclk_q);
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-1:0], pin};
  end

  assign rise = chain_q[STAGES-1] && !chain_q[STAGES];
  assign fall = !chain_q[STAGES-1] && chain_q[STAGES];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         msb_first,
  input  logic         rise,
  input  logic         fall,
  input  logic         sin,
  output logic [W-1:0] shreg,
  output logic         sout,
  output logic         active,
  output logic         done
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] ARM = CW'(W - 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          out_q, out_d;
  logic          en;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    out_d = out_q;
    done  = 1'b0;
    if (load) begin
      sh_d  = load_data;
      cnt_d = ARM;
      act_d = 1'b1;
    end else begin
      if (fall) out_d = msb_first ? sh_q[W-1] : sh_q[0];
      if (rise) begin
        sh_d = msb_first ? {sh_q[W-2:0], sin} : {sin, sh_q[W-1:1]};
        if (act_q) begin
          if (cnt_q == '0) begin
            act_d = 1'b0;
            done  = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign en = load || rise || fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      out_q <= 1'b1;
    end else if (en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
      out_q <= out_d;
    end
  end

  assign shreg  = sh_q;
  assign sout   = out_q;
  assign active = act_q;

  // R1: a load leaves the byte in place and the counter armed
  p_load_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_q && cnt_q == ARM && sh_q == $past(load_data)));
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int unsigned HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic             cpu_addr,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  input  logic             sin,
  output logic             sout,
  output logic             sout_oe,
  output logic             irq
);
  logic rs1_q, rs2_q, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  logic data_we, ctrl_we;
  assign data_we = cpu_we && (reg_sel_e'(cpu_addr) == SEL_DATA);
  assign ctrl_we = cpu_we && (reg_sel_e'(cpu_addr) == SEL_CTRL);

  logic ext_req_q, msb_q, flag_q, src_ext_q;
  logic ext_req_d, msb_d, flag_d, src_ext_d;
  logic active, done;
  logic int_rise, int_fall, ext_rise, ext_fall, rise, fall;
  logic [REG_W-1:0] shreg;

  sio_int_clk #(.HALF(HALF)) u_clk (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (data_we),
    .run   (active && !src_ext_q),
    .sclk  (sclk_out),
    .rise  (int_rise),
    .fall  (int_fall)
  );

  sio_edge_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .pin   (sclk_in),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  assign rise = src_ext_q ? ext_rise : int_rise;
  assign fall = src_ext_q ? ext_fall : int_fall;

  sio_shifter #(.W(REG_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (data_we),
    .load_data (cpu_wdata),
    .msb_first (msb_q),
    .rise      (rise),
    .fall      (fall),
    .sin       (sin),
    .shreg     (shreg),
    .sout      (sout),
    .active    (active),
    .done      (done)
  );

  always_comb begin
    ext_req_d = ext_req_q;
    msb_d     = msb_q;
    flag_d    = flag_q;
    src_ext_d = src_ext_q;
    if (ctrl_we) begin
      ext_req_d = cpu_wdata[CTL_EXT];
      msb_d     = cpu_wdata[CTL_MSB];
      if (!cpu_wdata[CTL_FLAG]) flag_d = 1'b0;
    end
    if (done) flag_d = 1'b1;
    if (data_we || !active) src_ext_d = ext_req_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ext_req_q <= 1'b0;
      msb_q     <= 1'b0;
    end else if (ctrl_we) begin
      ext_req_q <= ext_req_d;
      msb_q     <= msb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) flag_q <= 1'b0;
    else if (ctrl_we || done) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) src_ext_q <= 1'b0;
    else if (data_we || !active) src_ext_q <= src_ext_d;
  end

  always_comb begin
    cpu_rdata = shreg;
    if (reg_sel_e'(cpu_addr) == SEL_CTRL) begin
      cpu_rdata           = '0;
      cpu_rdata[CTL_EXT]  = ext_req_q;
      cpu_rdata[CTL_MSB]  = msb_q;
      cpu_rdata[CTL_FLAG] = flag_q;
    end
  end

  assign sclk_oe = !src_ext_q;
  assign sout_oe = src_ext_q || active;
  assign irq     = flag_q;

  // R7: the flag survives every cycle that lacks a clearing control write
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag_q && !(ctrl_we && !cpu_wdata[CTL_FLAG])) |=> flag_q);

  // R8: clock source frozen while a transfer runs
  p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (active && !data_we) |=> $stable(src_ext_q));

  // R6: completion in any mode raises the request one edge later
  p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> flag_q);

  // R4: an internal transfer ends with the clock high
  p_end_high_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($fell(active) && !src_ext_q) |-> sclk_out);
endmodule

// File: tb/tb_sio_port.sv
module tb_sio_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_we;
  logic       cpu_addr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       sclk_in;
  logic       sclk_out, sclk_oe, sin, sout, sout_oe, irq;

  always #(CLK_PERIOD/2) clk = !clk;

  sio_port #(.HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sin(sin), .sout(sout),
    .sout_oe(sout_oe), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic  exp_bit_q[$];
  string exp_tag_q[$];

  logic [7:0] rx_pat;
  logic       rx_msb;
  int         feed_idx;
  logic       running = 1'b0;
  logic       prev_lc = 1'b1;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cpu_wr(logic a, logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd_now(logic a, output logic [7:0] v);
    cpu_addr = a;
    #1;
    v = cpu_rdata;
  endtask

  // driver side: expected serial bits of a transfer
  task automatic push_tx(logic [7:0] b, logic msb, string tag);
    for (int i = 0; i < 8; i++) begin
      exp_bit_q.push_back(msb ? b[7-i] : b[i]);
      exp_tag_q.push_back(tag);
    end
  endtask

  task automatic ext_pulse();
    @(posedge clk); sclk_in <= 1'b0;
    repeat (6) @(posedge clk);
    sclk_in <= 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compare sout on every rising transfer clock, feed sin on falls
  always @(negedge clk) begin
    logic lc;
    lc = sclk_oe ? sclk_out : sclk_in;
    if (running) begin
      if (!prev_lc && lc) begin
        if (exp_bit_q.size() == 0) begin
          chk("R2 unexpected edge", 8'd1, 8'd0);
        end else begin
          logic  eb;
          string t;
          eb = exp_bit_q.pop_front();
          t  = exp_tag_q.pop_front();
          chk(t, {7'd0, sout}, {7'd0, eb});
        end
      end
      if (prev_lc && !lc) begin
        sin = (feed_idx < 8) ? (rx_msb ? rx_pat[7-feed_idx] : rx_pat[feed_idx]) : 1'b0;
        feed_idx++;
      end
    end
    prev_lc = lc;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = 1'b0; cpu_wdata = '0;
    sclk_in = 1'b1; sin = 1'b0; rx_pat = '0; rx_msb = 1'b0; feed_idx = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 sout_oe", {7'd0, sout_oe}, 8'd0);
    chk("R9 sclk_out", {7'd0, sclk_out}, 8'd1);
    chk("R9 sclk_oe", {7'd0, sclk_oe}, 8'd1);
    chk("R9 irq", {7'd0, irq}, 8'd0);
    rd_now(1'b0, v); chk("R9 data reg", v, 8'h00);
    rd_now(1'b1, v); chk("R9 ctrl reg", v, 8'h00);
    running = 1'b1;

    // internal clock, LSB first
    rx_pat = 8'h3C; rx_msb = 1'b0; feed_idx = 0;
    push_tx(8'hA5, 1'b0, "R2 lsb-first sout");
    cpu_wr(1'b0, 8'hA5);
    rd_now(1'b0, v); chk("R1 readback after write", v, 8'hA5);
    chk("R1 clock high after write", {7'd0, sclk_out}, 8'd1);
    chk("R5 sout_oe during transfer", {7'd0, sout_oe}, 8'd1);
    repeat (HALF-1) @(posedge clk);
    @(negedge clk); chk("R4 clock still high", {7'd0, sclk_out}, 8'd1);
    @(posedge clk);
    @(negedge clk); chk("R4 first falling edge", {7'd0, sclk_out}, 8'd0);
    repeat (16*HALF-1-HALF) @(posedge clk);
    @(negedge clk); chk("R4 irq not early", {7'd0, irq}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 irq on time", {7'd0, irq}, 8'd1);
    chk("R4 clock rests high", {7'd0, sclk_out}, 8'd1);
    chk("R5 sout floats after transfer", {7'd0, sout_oe}, 8'd0);
    rd_now(1'b0, v); chk("R3 lsb-first received", v, 8'h3C);

    // internal clock, MSB first; flag must survive non-clearing writes
    cpu_wr(1'b1, 8'hA0);
    chk("R7 writing 1 keeps flag", {7'd0, irq}, 8'd1);
    rd_now(1'b1, v); chk("R7 ctrl readback", v, 8'hA0);
    rx_pat = 8'h5A; rx_msb = 1'b1; feed_idx = 0;
    push_tx(8'h96, 1'b1, "R2 msb-first sout");
    cpu_wr(1'b0, 8'h96);
    chk("R7 data write keeps flag", {7'd0, irq}, 8'd1);
    repeat (8) @(posedge clk);
    cpu_wr(1'b1, 8'h21);
    chk("R7 flag cleared", {7'd0, irq}, 8'd0);
    chk("R8 source held mid-transfer", {7'd0, sclk_oe}, 8'd1);
    repeat (16*HALF-1-9) @(posedge clk);
    @(negedge clk); chk("R8 irq not early", {7'd0, irq}, 8'd0);
    @(posedge clk);
    @(negedge clk); chk("R8 internal timing kept", {7'd0, irq}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R8 external after idle", {7'd0, sclk_oe}, 8'd0);
    chk("R5 sout_oe in external mode", {7'd0, sout_oe}, 8'd1);
    rd_now(1'b0, v); chk("R3 msb-first received", v, 8'h5A);

    // external clock, LSB first
    cpu_wr(1'b1, 8'h01);
    chk("R7 clear by bit7=0", {7'd0, irq}, 8'd0);
    rx_pat = 8'hC5; rx_msb = 1'b0; feed_idx = 0;
    push_tx(8'h3C, 1'b0, "R2 external sout");
    for (int i = 0; i < 3; i++) begin
      exp_bit_q.push_back(rx_pat[i]);
      exp_tag_q.push_back("R6 continued shifting sout");
    end
    cpu_wr(1'b0, 8'h3C);
    rd_now(1'b0, v); chk("R1 external load", v, 8'h3C);
    for (int i = 0; i < 7; i++) ext_pulse();
    chk("R6 no irq after 7 edges", {7'd0, irq}, 8'd0);
    ext_pulse();
    chk("R6 irq after 8 edges", {7'd0, irq}, 8'd1);
    rd_now(1'b0, v); chk("R6 received byte", v, 8'hC5);
    for (int i = 0; i < 3; i++) ext_pulse();
    rd_now(1'b0, v); chk("R6 shifting continues", v, 8'h18);
    chk("R6 flag still set", {7'd0, irq}, 8'd1);
    chk("R2 all expected bits seen", 8'(exp_bit_q.size()), 8'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule